// File: doc/BRIEF.md
# E1 Signalling Multiframe Alignment Monitor

This block follows the signalling timeslot (timeslot 16) of an E1 receive stream and keeps track of the 16-frame signalling multiframe. It gathers the eight bits of timeslot 16 in every frame and searches for the all-zero four-bit alignment word. Once that word is found in a valid position, the block locks and counts frames modulo 16. It then reports loss of multiframe alignment when the word goes missing twice in a row, or when the signalling timeslot carried nothing but zeros for a whole multiframe.

The serial data arrives one bit per clock. Bit, timeslot and frame timing come from an upstream basic frame aligner as a timeslot index, a bit-within-timeslot index and a basic-alignment-valid flag. Downstream signalling logic uses the lock status and the recovered frame index. The loss status and its one-cycle interrupt pulse go to the alarm logic.

Top module: `mfa_monitor`

## Requirements
- R1: After reset the block is hunting: `mf_locked`=0, `mf_lost`=1, `mf_lost_irq`=0, `mf_index`=0.
- R2: Timeslot 16 is assembled with its first received bit as octet bit 7. The alignment word is octet bits 7..4, and it matches only when all four are 0.
- R3: While hunting with `bfa_ok`=1, a timeslot-16 octet that matches the alignment word is accepted if the previous timeslot-16 octet had at least one 1. On the clock edge of that octet's last bit the block sets `mf_locked`=1, `mf_lost`=0 and `mf_index`=1.
- R4: While hunting, no lock is taken if the previous timeslot-16 octet was all zero, or if `bfa_ok` is 0 during the octet's last bit.
- R5: While locked, every completed timeslot-16 octet advances `mf_index` by one, modulo 16. At every other edge it holds. While hunting it is 0.
- R6: A single frame-0 octet without the alignment word keeps the lock. A frame-0 octet that carries the word clears the count of misses.
- R7: A second consecutive frame-0 octet without the alignment word declares loss at the edge of its last bit.
- R8: If all sixteen timeslot-16 octets of a locked multiframe (index 0 to 15) are zero, loss is declared at the edge of the last bit of index 15.
- R9: When `bfa_ok` is 0 at any edge, the block goes to hunting at that edge with `mf_lost`=1 and `mf_index`=0. This takes precedence over any octet evaluation in the same cycle.
- R10: `mf_lost_irq` is high for exactly one cycle each time `mf_lost` goes from 0 to 1. It never pulses at reset, or when loss is already set.
- R11: Bits received outside timeslot 16 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial receive data, one bit per clock |
| ts_idx | input | 5 | Timeslot index of the current bit (0..31) |
| bit_idx | input | 3 | Bit position within the timeslot, 0 = first received |
| bfa_ok | input | 1 | Basic frame alignment valid |
| mf_locked | output | 1 | Multiframe alignment held |
| mf_lost | output | 1 | Loss of multiframe alignment status |
| mf_lost_irq | output | 1 | One-cycle pulse when loss is declared |
| mf_index | output | 4 | Index of the next timeslot-16 octet within the multiframe |

## Verification
The dangerous coincidence is a drop of basic frame alignment at the same edge that completes a frame-0 octet which would itself declare loss, the second consecutive miss. The bench builds up one miss and then pulls `bfa_ok` low during the last bit of the second missing word. The block must then be hunting with loss set, raise exactly one interrupt cycle and leave `mf_index` at 0. The random phase keeps mixing alignment drops, all-zero octets and false candidates, all judged against a bench model of the requirements.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } mfa_state_e;

  localparam int unsigned OCTET_W = 8;
  localparam int unsigned BITPOS_W = 3;
endpackage

// File: rtl/mfa_ts16_grab.sv
module mfa_ts16_grab
  import mfa_pkg::*;
#(
  parameter int unsigned SLOT_W   = 5,
  parameter int unsigned SIG_SLOT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_bit,
  input  logic [SLOT_W-1:0]    ts_idx,
  input  logic [BITPOS_W-1:0]  bit_idx,
  output logic                 oct_evt,
  output logic [OCTET_W-1:0]   octet
);
  localparam logic [BITPOS_W-1:0] LAST_BIT = BITPOS_W'(OCTET_W - 1);

  logic               in_slot;
  logic [OCTET_W-2:0] sh_q, sh_d;

  assign in_slot = (ts_idx == SLOT_W'(SIG_SLOT));

  always_comb begin
    sh_d = {sh_q[OCTET_W-3:0], rx_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (in_slot) begin
      sh_q <= sh_d;
    end
  end

  assign oct_evt = in_slot && (bit_idx == LAST_BIT);
  assign octet   = {sh_q, rx_bit};
endmodule

// File: rtl/mfa_zero_watch.sv
module mfa_zero_watch
  import mfa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oct_evt,
  input  logic [OCTET_W-1:0] octet,
  input  logic               mf_first,
  output logic               prev_nz,
  output logic               zacc
);
  logic oct_zero;
  logic prev_nz_d, zacc_d;

  assign oct_zero = (octet == '0);

  always_comb begin
    prev_nz_d = !oct_zero;
    zacc_d    = mf_first ? oct_zero : (zacc && oct_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nz <= 1'b0;
      zacc    <= 1'b0;
    end else if (oct_evt) begin
      prev_nz <= prev_nz_d;
      zacc    <= zacc_d;
    end
  end

  assert_zacc_breaks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_evt && !oct_zero) |=> !zacc);

  assert_prev_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_evt && oct_zero) |=> !prev_nz);
endmodule

// File: rtl/mfa_align_fsm.sv
module mfa_align_fsm
  import mfa_pkg::*;
#(
  parameter int unsigned MF_LEN     = 16,
  parameter int unsigned MISS_LIMIT = 2,
  parameter int unsigned CNT_W      = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oct_evt,
  input  logic             word_ok,
  input  logic             oct_zero,
  input  logic             prev_nz,
  input  logic             zacc,
  input  logic             bfa_ok,
  output logic             locked,
  output logic             lost,
  output logic             lost_irq,
  output logic             mf_first,
  output logic [CNT_W-1:0] mf_idx
);
  localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LAST_IDX  = CNT_W'(MF_LEN - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

  mfa_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              lost_q, lost_d;
  logic              irq_q, irq_d;
  logic              loss_c;
  logic              upd_en;

  assign upd_en = oct_evt || !bfa_ok || irq_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    miss_d = miss_q;
    lost_d = lost_q;
    irq_d  = 1'b0;
    loss_c = 1'b0;
    if (!bfa_ok) begin
      st_d   = ST_HUNT;
      cnt_d  = '0;
      miss_d = '0;
      lost_d = 1'b1;
      irq_d  = !lost_q;
    end else if (oct_evt) begin
      if (st_q == ST_HUNT) begin
        if (word_ok && prev_nz) begin
          st_d   = ST_LOCK;
          cnt_d  = CNT_W'(1);
          miss_d = '0;
          lost_d = 1'b0;
        end
      end else begin
        if (cnt_q == '0) begin
          if (word_ok) begin
            miss_d = '0;
          end else if (miss_q == MISS_LAST) begin
            loss_c = 1'b1;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
        if ((cnt_q == LAST_IDX) && zacc && oct_zero) begin
          loss_c = 1'b1;
        end
        if (loss_c) begin
          st_d   = ST_HUNT;
          cnt_d  = '0;
          miss_d = '0;
          lost_d = 1'b1;
          irq_d  = 1'b1;
        end else begin
          cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      miss_q <= '0;
      lost_q <= 1'b1;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      miss_q <= miss_d;
      lost_q <= lost_d;
      irq_q  <= irq_d;
    end
  end

  assign locked   = (st_q == ST_LOCK);
  assign lost     = lost_q;
  assign lost_irq = irq_q;
  assign mf_idx   = cnt_q;
  assign mf_first = (st_q == ST_HUNT) || (cnt_q == '0);

  assert_bfa_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bfa_ok |=> (!locked && lost && mf_idx == '0));

  assert_lock_lost_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked != lost);

  assert_irq_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> lost_irq);

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lost_irq |=> !lost_irq);

  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oct_evt && bfa_ok) |=> $stable(mf_idx));

  assert_hunt_idx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (mf_idx == '0));
endmodule

// File: rtl/mfa_monitor.sv
module mfa_monitor
  import mfa_pkg::*;
#(
  parameter int unsigned SLOTS      = 32,
  parameter int unsigned SIG_SLOT   = 16,
  parameter int unsigned MF_LEN     = 16,
  parameter int unsigned WORD_BITS  = 4,
  parameter int unsigned MISS_LIMIT = 2,
  parameter int unsigned SLOT_W     = $clog2(SLOTS),
  parameter int unsigned CNT_W      = $clog2(MF_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_bit,
  input  logic [SLOT_W-1:0]   ts_idx,
  input  logic [BITPOS_W-1:0] bit_idx,
  input  logic                bfa_ok,
  output logic                mf_locked,
  output logic                mf_lost,
  output logic                mf_lost_irq,
  output logic [CNT_W-1:0]    mf_index
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               oct_evt;
  logic [OCTET_W-1:0] octet;
  logic               word_ok, oct_zero;
  logic               prev_nz, zacc, mf_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  mfa_ts16_grab #(
    .SLOT_W   (SLOT_W),
    .SIG_SLOT (SIG_SLOT)
  ) u_grab (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rx_bit  (rx_bit),
    .ts_idx  (ts_idx),
    .bit_idx (bit_idx),
    .oct_evt (oct_evt),
    .octet   (octet)
  );

  assign word_ok  = (octet[OCTET_W-1 -: WORD_BITS] == '0);
  assign oct_zero = (octet == '0);

  mfa_zero_watch u_zero (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .oct_evt  (oct_evt),
    .octet    (octet),
    .mf_first (mf_first),
    .prev_nz  (prev_nz),
    .zacc     (zacc)
  );

  mfa_align_fsm #(
    .MF_LEN     (MF_LEN),
    .MISS_LIMIT (MISS_LIMIT),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .oct_evt  (oct_evt),
    .word_ok  (word_ok),
    .oct_zero (oct_zero),
    .prev_nz  (prev_nz),
    .zacc     (zacc),
    .bfa_ok   (bfa_ok),
    .locked   (mf_locked),
    .lost     (mf_lost),
    .lost_irq (mf_lost_irq),
    .mf_first (mf_first),
    .mf_idx   (mf_index)
  );

  assert_quiet_outside_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!oct_evt && bfa_ok) |=> ($stable(mf_locked) && $stable(mf_lost)));
endmodule

// File: tb/sim_mfa_monitor.sv
module sim_mfa_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_bit;
  logic [4:0] ts_idx;
  logic [2:0] bit_idx;
  logic       bfa_ok;
  logic       mf_locked, mf_lost, mf_lost_irq;
  logic [3:0] mf_index;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  bit       m_lock, m_lost, m_irq, m_prevnz, m_zacc;
  int       m_cnt, m_miss;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfa_monitor u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_bit      (rx_bit),
    .ts_idx      (ts_idx),
    .bit_idx     (bit_idx),
    .bfa_ok      (bfa_ok),
    .mf_locked   (mf_locked),
    .mf_lost     (mf_lost),
    .mf_lost_irq (mf_lost_irq),
    .mf_index    (mf_index)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(mf_locked == m_lock, req, "locked", mf_locked, m_lock);
    chk(mf_lost == m_lost, req, "lost", mf_lost, m_lost);
    chk(mf_lost_irq == m_irq, req, "irq", mf_lost_irq, m_irq);
    chk(int'(mf_index) == m_cnt, req, "index", mf_index, m_cnt);
  endtask

  function automatic void model_drop();
    m_irq  = !m_lost;
    m_lock = 1'b0;
    m_lost = 1'b1;
    m_cnt  = 0;
    m_miss = 0;
  endfunction

  function automatic void model_evt(input logic [7:0] oct, input bit bfa);
    bit nz, first, loss;
    nz    = (oct != 8'h00);
    first = !m_lock || (m_cnt == 0);
    m_irq = 1'b0;
    if (!bfa) begin
      model_drop();
    end else if (!m_lock) begin
      if (oct[7:4] == 4'h0 && m_prevnz) begin
        m_lock = 1'b1; m_lost = 1'b0; m_cnt = 1; m_miss = 0;
      end
    end else begin
      loss = 1'b0;
      if (m_cnt == 0) begin
        if (oct[7:4] == 4'h0) m_miss = 0;
        else if (m_miss == 1) loss = 1'b1;
        else m_miss = 1;
      end
      if (m_cnt == 15 && m_zacc && !nz) loss = 1'b1;
      if (loss) begin
        m_lock = 1'b0; m_lost = 1'b1; m_irq = 1'b1; m_cnt = 0; m_miss = 0;
      end else begin
        m_cnt = (m_cnt + 1) % 16;
      end
    end
    m_zacc   = first ? !nz : (m_zacc && !nz);
    m_prevnz = nz;
  endfunction

  task automatic idle_cycle();
    logic [4:0] t;
    t = 5'($urandom_range(0, 31));
    if (t == 5'd16) t = 5'd17;
    ts_idx  = t;
    bit_idx = 3'($urandom_range(0, 7));
    rx_bit  = 1'($urandom);
  endtask

  task automatic send_oct(input logic [7:0] oct, input bit bfa_last, input string req);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      ts_idx  = 5'd16;
      bit_idx = 3'(b);
      rx_bit  = oct[7-b];
      bfa_ok  = (b == 7) ? bfa_last : 1'b1;
    end
    @(negedge clk);
    bfa_ok = 1'b1;
    model_evt(oct, bfa_last);
    compare_all(req);
    idle_cycle();
    @(negedge clk);
    m_irq = 1'b0;
    compare_all("R11");
    idle_cycle();
  endtask

  task automatic drop_bfa(input string req);
    @(negedge clk);
    idle_cycle();
    bfa_ok = 1'b0;
    @(negedge clk);
    bfa_ok = 1'b1;
    model_drop();
    compare_all(req);
    idle_cycle();
    @(negedge clk);
    m_irq = 1'b0;
    compare_all(req);
  endtask

  function automatic logic [7:0] rand_oct();
    int p;
    p = $urandom_range(0, 99);
    if (m_lock && m_cnt == 0 && p < 75) return {4'h0, 4'($urandom)};
    if (p < 15) return 8'h00;
    if (p < 30) return {4'h0, 4'($urandom)};
    return 8'($urandom);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; rx_bit = 1'b0; ts_idx = 5'd0; bit_idx = 3'd0; bfa_ok = 1'b1;
    m_lock = 0; m_lost = 1; m_irq = 0; m_prevnz = 0; m_zacc = 0; m_cnt = 0; m_miss = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1");

    // R4: candidate with all-zero predecessor is refused
    send_oct(8'h00, 1'b1, "R4");
    send_oct(8'h00, 1'b1, "R4");
    // R2: ones in the first four received bits do not match
    send_oct(8'hF0, 1'b1, "R2");
    // R4: alignment dropped on the candidate's last bit
    send_oct(8'h0F, 1'b0, "R4");
    send_oct(8'h5A, 1'b1, "R4");
    // R3: valid candidate
    send_oct(8'h0F, 1'b1, "R3");
    // R5: count through a full multiframe
    for (int i = 0; i < 15; i++) send_oct(8'hA5, 1'b1, "R5");
    send_oct(8'h07, 1'b1, "R6");
    for (int i = 0; i < 15; i++) send_oct(8'h3C, 1'b1, "R5");
    // R6: one miss then a hit clears it
    send_oct(8'h80, 1'b1, "R6");
    for (int i = 0; i < 15; i++) send_oct(8'h3C, 1'b1, "R6");
    send_oct(8'h01, 1'b1, "R6");
    for (int i = 0; i < 15; i++) send_oct(8'h3C, 1'b1, "R6");
    // R7: two consecutive misses
    send_oct(8'h90, 1'b1, "R7");
    for (int i = 0; i < 15; i++) send_oct(8'h3C, 1'b1, "R7");
    send_oct(8'hE0, 1'b1, "R7");
    // R8: relock on a zero octet, then a silent multiframe
    send_oct(8'h00, 1'b1, "R3");
    for (int i = 0; i < 15; i++) send_oct(8'h00, 1'b1, "R8");
    // R9/R10: drop while locked, then while already lost
    send_oct(8'h11, 1'b1, "R3");
    send_oct(8'h02, 1'b1, "R3");
    drop_bfa("R9");
    drop_bfa("R10");
    // R9/R10: drop coinciding with the second miss
    send_oct(8'h44, 1'b1, "R3");
    send_oct(8'h03, 1'b1, "R3");
    for (int i = 0; i < 15; i++) send_oct(8'h3C, 1'b1, "R5");
    send_oct(8'hC0, 1'b1, "R6");
    for (int i = 0; i < 15; i++) send_oct(8'h3C, 1'b1, "R5");
    send_oct(8'hC0, 1'b0, "R9");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 99) < 2) drop_bfa("R9");
      else send_oct(rand_oct(), ($urandom_range(0, 99) >= 1), "R5");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule